// File: doc/BRIEF.md
# Global 64-bit Timebase with Self-Advancing Comparator

The block is a free-running 64-bit up-counter that serves as the system timebase. Software reaches it through a small register window of 32-bit words. The counter is read and written as two halves. A prescaler sets its rate. A 64-bit comparator raises an event flag once the count has reached or passed a programmed value. One level interrupt output reflects that flag, gated by an enable bit.

The low half of the count wraps cleanly into the high half, so software may treat the low word alone as a 32-bit timebase. The comparator can also add a programmed step to itself each time it matches. This gives a periodic event stream from a counter that is never stopped or reloaded.

The register window decodes the byte address `bus_addr`. Reads are combinational from the address. A write takes effect at the rising clock edge while `bus_we` is high. Unmapped offsets read as zero and ignore writes.

Top module: `gtb_timebase`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While control bit 0 (run) is set, the count rises by one once every P+1 clock cycles, where P is the prescale field in control bits [15:8]. A change to the control register takes effect from the cycle after the write.
- R3: While run is clear, the count holds its value. Writing zero to the control register at offset 0x08 halts the counter.
- R4: When the low word (offset 0x00) steps from 0xFFFFFFFF, it becomes 0 and the high word (offset 0x04) increases by one.
- R5: A write to offset 0x00 or 0x04 replaces that half of the count, and takes precedence over an increment in the same cycle.
- R6: While control bit 1 (compare enable) is set and the 64-bit count is greater than or equal to the comparator (low word at 0x10, high word at 0x14), status bit 0 (offset 0x0C) reads 1 from the next cycle on.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A compare hit in the same cycle keeps the flag set.
- R8: While control bit 3 (auto-advance) and compare enable are both set, each cycle with a compare hit adds the 32-bit step value (offset 0x18) to the 64-bit comparator. A direct write to a comparator half overrides the advance for that half.
- R9: `irq` is high exactly when status bit 0 is set and control bit 2 (interrupt enable) is set.
- R10: While compare enable is clear, a clear flag stays clear, whatever the count and comparator hold.
- R11: Control bits outside bits 0 to 3 and the prescale field read as zero. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Compare interrupt, the flag gated by the enable bit |

## Verification
The bench drives the low word across its all-ones value. A design without the carry would leave the high word unchanged, and one that wraps wrongly would show a non-zero low word. The bench clears the flag while the comparator is disabled, and again during a hit. A wrong priority would show a stale flag, or lose the event. Auto-advance runs against a slow prescale and a fast one. A comparator that advanced only once, or used the wrong step, would drift from the expected value. Random control words with changing prescale values check that the P+1 spacing restarts correctly. An off-by-one divider would skew every later count read.

// File: rtl/gtb_pkg.sv
package gtb_pkg;
   // Byte offsets of the register window
   localparam logic [7:0] OFF_CNT_LO = 8'h00;
   localparam logic [7:0] OFF_CNT_HI = 8'h04;
   localparam logic [7:0] OFF_CTRL   = 8'h08;
   localparam logic [7:0] OFF_STAT   = 8'h0C;
   localparam logic [7:0] OFF_CMP_LO = 8'h10;
   localparam logic [7:0] OFF_CMP_HI = 8'h14;
   localparam logic [7:0] OFF_STEP   = 8'h18;

   // Control word bit positions
   localparam int CB_RUN    = 0;
   localparam int CB_CMP_EN = 1;
   localparam int CB_IRQ_EN = 2;
   localparam int CB_AUTO   = 3;
   localparam int CB_PSC_LO = 8;
   localparam int SB_FLAG   = 0;

   typedef struct packed {
      logic auto_adv;
      logic irq_en;
      logic cmp_en;
      logic run;
   } ctrl_bits_t;
endpackage

// File: rtl/gtb_prescaler.sv
module gtb_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run,
   input  logic [(PSC_W>0?PSC_W:1)-1:0] psc,
   output logic                        tick
);
   localparam int PW = (PSC_W > 0) ? PSC_W : 1;

   generate
      if (PSC_W == 0) begin : g_direct
         // no divider: one step per enabled cycle
         assign tick = run;
         logic unused_psc;
         assign unused_psc = ^psc;
      end else begin : g_divider
         logic [PW-1:0] div_q;

         assign tick = run && (div_q == psc);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (!run || tick)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end

         // two ticks in a row are only possible with a zero prescale (R2)
         p_tick_spacing_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (tick && $past(tick)) |-> (psc == '0));
      end
   endgenerate
endmodule

// File: rtl/gtb_counter.sv
module gtb_counter #(
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  wr_lo,
   input  logic                  wr_hi,
   input  logic [WORD_W-1:0]     wdata,
   output logic [2*WORD_W-1:0]   count
);
   localparam int CNT_W = 2 * WORD_W;

   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_inc = tick ? (count + CNT_W'(1)) : count;
      cnt_nxt = cnt_inc;
      if (wr_lo) cnt_nxt[WORD_W-1:0]     = wdata;
      if (wr_hi) cnt_nxt[CNT_W-1:WORD_W] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else
         count <= cnt_nxt;
   end

   p_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && !$past(wr_lo) && !$past(wr_hi)) |-> (count == $past(count) + CNT_W'(1)));

   p_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tick) && !$past(wr_lo) && !$past(wr_hi)) |-> (count == $past(count)));

   p_carry_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && !$past(wr_lo) && !$past(wr_hi) && ($past(count[WORD_W-1:0]) == {WORD_W{1'b1}}))
      |-> ((count[WORD_W-1:0] == '0) && (count[CNT_W-1:WORD_W] == $past(count[CNT_W-1:WORD_W]) + 1'b1)));

   p_write_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_hi) |-> (count[CNT_W-1:WORD_W] == $past(wdata)));
endmodule

// File: rtl/gtb_comparator.sv
module gtb_comparator #(
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*WORD_W-1:0]   count,
   input  logic                  cmp_en,
   input  logic                  auto_adv,
   input  logic                  wr_lo,
   input  logic                  wr_hi,
   input  logic                  wr_step,
   input  logic [WORD_W-1:0]     wdata,
   output logic                  hit,
   output logic [2*WORD_W-1:0]   cmp,
   output logic [WORD_W-1:0]     step
);
   localparam int CNT_W = 2 * WORD_W;

   logic [CNT_W-1:0] cmp_nxt;

   assign hit = cmp_en && (count >= cmp);

   always_comb begin
      cmp_nxt = (hit && auto_adv) ? (cmp + CNT_W'(step)) : cmp;
      if (wr_lo) cmp_nxt[WORD_W-1:0]     = wdata;
      if (wr_hi) cmp_nxt[CNT_W-1:WORD_W] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp  <= '0;
         step <= '0;
      end else begin
         cmp <= cmp_nxt;
         if (wr_step) step <= wdata;
      end
   end

   p_advance_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit && auto_adv && !wr_lo && !wr_hi) |-> (cmp == $past(cmp) + CNT_W'($past(step))));

   p_still_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(!hit && !wr_lo && !wr_hi) |-> (cmp == $past(cmp)));
endmodule

// File: rtl/gtb_timebase.sv
module gtb_timebase #(
   parameter int WORD_W = 32,
   parameter int PSC_W  = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              irq
);
   import gtb_pkg::*;

   localparam int CNT_W = 2 * WORD_W;
   localparam int PW    = (PSC_W > 0) ? PSC_W : 1;

   generate
      if (CB_PSC_LO + PSC_W > WORD_W) begin : g_bad_psc
         $error("prescale field does not fit in the control word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("address too narrow for the register window");
      end
   endgenerate

   // Address decode
   logic sel_cnt_lo, sel_cnt_hi, sel_ctrl, sel_stat, sel_cmp_lo, sel_cmp_hi, sel_step;
   assign sel_cnt_lo = (bus_addr == ADDR_W'(OFF_CNT_LO));
   assign sel_cnt_hi = (bus_addr == ADDR_W'(OFF_CNT_HI));
   assign sel_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
   assign sel_stat   = (bus_addr == ADDR_W'(OFF_STAT));
   assign sel_cmp_lo = (bus_addr == ADDR_W'(OFF_CMP_LO));
   assign sel_cmp_hi = (bus_addr == ADDR_W'(OFF_CMP_HI));
   assign sel_step   = (bus_addr == ADDR_W'(OFF_STEP));

   // Control register
   ctrl_bits_t    ctl;
   logic [PW-1:0] psc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl   <= '0;
         psc_q <= '0;
      end else if (bus_we && sel_ctrl) begin
         ctl.run      <= bus_wdata[CB_RUN];
         ctl.cmp_en   <= bus_wdata[CB_CMP_EN];
         ctl.irq_en   <= bus_wdata[CB_IRQ_EN];
         ctl.auto_adv <= bus_wdata[CB_AUTO];
         if (PSC_W > 0) psc_q <= bus_wdata[CB_PSC_LO +: PW];
      end
   end

   logic tick;
   gtb_prescaler #(.PSC_W(PSC_W)) i_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctl.run),
      .psc  (psc_q),
      .tick (tick)
   );

   logic [CNT_W-1:0] count;
   gtb_counter #(.WORD_W(WORD_W)) i_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .wr_lo(bus_we && sel_cnt_lo),
      .wr_hi(bus_we && sel_cnt_hi),
      .wdata(bus_wdata),
      .count(count)
   );

   logic              hit;
   logic [CNT_W-1:0]  cmp;
   logic [WORD_W-1:0] step;
   gtb_comparator #(.WORD_W(WORD_W)) i_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count),
      .cmp_en  (ctl.cmp_en),
      .auto_adv(ctl.auto_adv),
      .wr_lo   (bus_we && sel_cmp_lo),
      .wr_hi   (bus_we && sel_cmp_hi),
      .wr_step (bus_we && sel_step),
      .wdata   (bus_wdata),
      .hit     (hit),
      .cmp     (cmp),
      .step    (step)
   );

   // Event flag: a hit wins over a write-one clear
   logic flag;
   logic clr_req;
   assign clr_req = bus_we && sel_stat && bus_wdata[SB_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (hit)
         flag <= 1'b1;
      else if (clr_req)
         flag <= 1'b0;
   end

   assign irq = flag && ctl.irq_en;

   // Read mux
   logic [WORD_W-1:0] ctrl_rd;
   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[CB_RUN]    = ctl.run;
      ctrl_rd[CB_CMP_EN] = ctl.cmp_en;
      ctrl_rd[CB_IRQ_EN] = ctl.irq_en;
      ctrl_rd[CB_AUTO]   = ctl.auto_adv;
      if (PSC_W > 0) ctrl_rd[CB_PSC_LO +: PW] = psc_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_cnt_lo) bus_rdata = count[WORD_W-1:0];
      if (sel_cnt_hi) bus_rdata = count[CNT_W-1:WORD_W];
      if (sel_ctrl)   bus_rdata = ctrl_rd;
      if (sel_stat)   bus_rdata[SB_FLAG] = flag;
      if (sel_cmp_lo) bus_rdata = cmp[WORD_W-1:0];
      if (sel_cmp_hi) bus_rdata = cmp[CNT_W-1:WORD_W];
      if (sel_step)   bus_rdata = step;
   end

   p_flag_set_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit) |-> flag);

   p_clear_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(!hit && clr_req) |-> !flag);

   p_irq_rise_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag) && ctl.irq_en) |-> irq);

   p_irq_needs_flag_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   p_quiet_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!ctl.cmp_en) && $past(!flag)) |-> !flag);
endmodule

// File: tb/test_gtb_timebase.sv
module test_gtb_timebase;
   localparam int CLK_PERIOD = 10;
   localparam int SEED       = 1234;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   gtb_timebase i_gtb_timebase (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Expected-state model built from the requirements
   logic [63:0] m_cnt, m_cmp;
   logic [31:0] m_ctrl, m_step;
   logic [7:0]  m_div;
   logic        m_flag;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0; m_cmp <= '0; m_ctrl <= '0; m_step <= '0; m_div <= '0; m_flag <= 1'b0;
      end else begin
         logic tk, ht;
         logic [63:0] nc, nm;
         tk = m_ctrl[0] && (m_div == m_ctrl[15:8]);                 // R2
         ht = m_ctrl[1] && (m_cnt >= m_cmp);                         // R6
         m_div <= (!m_ctrl[0] || tk) ? 8'd0 : m_div + 8'd1;
         nc = tk ? m_cnt + 64'd1 : m_cnt;
         nm = (ht && m_ctrl[3]) ? m_cmp + {32'd0, m_step} : m_cmp;   // R8
         if (bus_we) begin
            case (bus_addr)
               5'h00: nc[31:0]  = bus_wdata;
               5'h04: nc[63:32] = bus_wdata;
               5'h08: m_ctrl   <= bus_wdata & 32'h0000_FF0F;         // R11
               5'h10: nm[31:0]  = bus_wdata;
               5'h14: nm[63:32] = bus_wdata;
               5'h18: m_step   <= bus_wdata;
               default: ;
            endcase
         end
         m_cnt <= nc;
         m_cmp <= nm;
         if (ht) m_flag <= 1'b1;
         else if (bus_we && bus_addr == 5'h0C && bus_wdata[0]) m_flag <= 1'b0;
      end
   end

   function automatic logic [31:0] exp_rd(input logic [4:0] a);
      case (a)
         5'h00: return m_cnt[31:0];
         5'h04: return m_cnt[63:32];
         5'h08: return m_ctrl;
         5'h0C: return {31'd0, m_flag};
         5'h10: return m_cmp[31:0];
         5'h14: return m_cmp[63:32];
         5'h18: return m_step;
         default: return 32'd0;
      endcase
   endfunction

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_rd(input logic [4:0] a, input string tag);
      logic [31:0] e;
      bus_we = 1'b0; bus_addr = a; #1;
      e = exp_rd(a);
      checks++;
      if (bus_rdata !== e) begin
         errors++;
         $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
      end
   endtask

   task automatic chk_val(input logic [4:0] a, input logic [31:0] e, input string tag);
      bus_we = 1'b0; bus_addr = a; #1;
      checks++;
      if (bus_rdata !== e) begin
         errors++;
         $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
      end
   endtask

   task automatic chk_irq(input string tag);
      logic e;
      #1;
      e = m_flag && m_ctrl[2];
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: irq got %0b expected %0b", tag, irq, e);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(SEED);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) chk_val(5'(a * 4), 32'd0, "R1");
      chk_irq("R1");

      // R11: reserved control bits read zero, unmapped offset reads zero
      wr(5'h08, 32'hFFFF_F0F0);
      chk_val(5'h08, 32'h0000_F000, "R11");
      chk_val(5'h1C, 32'd0, "R11");
      wr(5'h08, 32'h0);

      // R2: prescale 2 and prescale 0
      wr(5'h08, 32'h0000_0201);
      idle(10); chk_rd(5'h00, "R2");
      idle(7);  chk_rd(5'h00, "R2");
      wr(5'h08, 32'h0000_0001);
      idle(5);  chk_rd(5'h00, "R2");

      // R3: halt holds the count
      wr(5'h08, 32'h0);
      chk_rd(5'h00, "R3");
      idle(6); chk_rd(5'h00, "R3");

      // R4: low word wraps into high word
      wr(5'h00, 32'hFFFF_FFFE);
      wr(5'h04, 32'h0000_0005);
      wr(5'h08, 32'h0000_0001);
      idle(4);
      wr(5'h08, 32'h0);
      chk_val(5'h04, 32'h0000_0006, "R4");
      chk_rd(5'h00, "R4");

      // R5: write to a count half
      wr(5'h04, 32'h0000_1234);
      chk_val(5'h04, 32'h0000_1234, "R5");
      wr(5'h00, 32'd100);
      chk_val(5'h00, 32'd100, "R5");

      // R6, R9: compare hit raises flag and interrupt
      wr(5'h10, 32'd110);
      wr(5'h14, 32'h0000_1234);
      wr(5'h08, 32'h0000_0007);
      idle(15);
      chk_val(5'h0C, 32'd1, "R6");
      chk_irq("R9");
      wr(5'h08, 32'h0000_0003);  // interrupt gate off
      chk_irq("R9");

      // R7, R10: clear behaviour with the comparator disabled
      wr(5'h08, 32'h0000_0005);
      wr(5'h0C, 32'h0);
      chk_val(5'h0C, 32'd1, "R7");
      wr(5'h0C, 32'h1);
      chk_val(5'h0C, 32'd0, "R7");
      chk_irq("R7");
      idle(8);
      chk_val(5'h0C, 32'd0, "R10");
      // R7: clear during a hit keeps the flag
      wr(5'h08, 32'h0000_0003);
      idle(2);
      wr(5'h0C, 32'h1);
      chk_val(5'h0C, 32'd1, "R7");

      // R8: auto-advance, fast then slow prescale
      wr(5'h08, 32'h0);
      wr(5'h00, 32'd0);
      wr(5'h04, 32'd0);
      wr(5'h10, 32'd5);
      wr(5'h14, 32'd0);
      wr(5'h18, 32'd4);
      wr(5'h08, 32'h0000_000B);
      idle(20); chk_rd(5'h10, "R8");
      wr(5'h08, 32'h0000_030B);
      idle(25); chk_rd(5'h10, "R8"); chk_rd(5'h00, "R8");
      wr(5'h08, 32'h0);
      chk_rd(5'h14, "R8");

      // Random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         op = int'($urandom % 8);
         case (op)
            0: wr(5'h08, ($urandom % 4) << 8 | ($urandom % 16));
            1: wr(5'h10, m_cnt[31:0] + ($urandom % 24));
            2: wr(5'h14, m_cnt[63:32]);
            3: wr(5'h18, $urandom % 9);
            4: wr(5'h0C, $urandom % 2);
            5: wr(5'h00, ($urandom % 2) ? 32'hFFFF_FFF0 : $urandom);
            default: idle(int'($urandom % 6));
         endcase
         chk_rd(5'(($urandom % 7) * 4), "R2");
         if (i % 10 == 0) chk_irq("R9");
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule